// File: doc/BRIEF.md
# Three-Rail Power-Up Sequencing and Tracking Controller

This block is the digital control core of a supply manager for three switched rails. Analog comparators, charge pumps and gate drivers are outside it. It reads thresholded flags for each rail: input good, input absent, output good, output low and tracking error. It also reads a supply-ok flag for the internal supply, an enable, a mode select and a retry/latch select. It drives a gate enable and a discharge-pulldown enable for each rail, a power-good flag, a soft-off flag for a controlled ramp-down, and an active-low fault.

In tracking mode every rail's gate is enabled together after a start-up delay. In sequencing mode the rails come up one at a time: rail 0, then rail 1, then rail 2. The same delay runs before each rail, and the next delay starts only when the previous rail reports output good. A fault window bounds each power-up phase, and a tracking error beyond the limit also causes a fault. After a fault the block either retries after 16 fault windows or stays latched until the enable is cycled. All times are cycle counts set by parameters.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the outputs are gate_en=0, dis_en=0, soft_off=0, pwr_good=0 and fault_n=1. Power-up starts only when supply_ok, en and every in_good bit are 1 and every out_low bit is 1; until then no gate is enabled.
- R2: The first gate enable appears DLY_CYC+1 cycles after the first cycle in which the start conditions are presented, counted to the clock edge. Outputs do not change in between.
- R3: In tracking mode (mode_seq=0) all controlled gates turn on in the same cycle. pwr_good rises TMO_CYC+1 cycles after all controlled out_good bits are presented.
- R4: In sequencing mode (mode_seq=1) rail 0 turns on first, then rail 1, then rail 2. Rail i+1's gate appears DLY_CYC+1 cycles after rail i's out_good is presented.
- R5: If a rail's gate has been on for FLT_CYC cycles without power-up completing, the next state is a fault. In that state fault_n=0, all gates are off and discharge is on.
- R6: A trk_err bit on a controlled rail during a tracking ramp-up or a controlled ramp-down causes the fault state on the next clock edge.
- R7: dis_en is 1 on the controlled rails only in fast shutdown, fault wait and latched states. It is 0 whenever a gate is enabled, during ramp-down and in idle.
- R8: With autoretry (retry_sel=1 when last idle), the fault holds for 16*FLT_CYC cycles. A new attempt then starts if en, every in_good bit and every out_low bit are 1. fault_n returns to 1 in the cycle the attempt starts.
- R9: With latch-off (retry_sel=0 when last idle), the fault holds however long en stays high. After en goes low and then high, one retry period of 16*FLT_CYC cycles passes before a new attempt.
- R10: When supply_ok drops, all gates and discharge turn off and fault_n returns to 1. When supply_ok returns, power-up starts with only the start-up delay and no retry wait.
- R11: If en drops before pwr_good has asserted, gates turn off, discharge turns on and fault_n stays 1. The block returns to idle once every out_low bit is 1.
- R12: If en drops while pwr_good is 1, the block does a controlled ramp-down. All gates turn off together, soft_off=1 and discharge stays off. This applies in both modes. The block returns to idle once outputs are low.
- R13: A rail with in_absent=1 and in_good=1 is excluded. Its gate and discharge stay 0. Its out_good, out_low and trk_err bits are ignored.
- R14: mode_seq and retry_sel are sampled only in idle. A change during an attempt or a fault wait takes effect at the next attempt that starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| supply_ok | input | 1 | Internal supply is above its lockout level |
| en | input | 1 | Enable input above its threshold |
| mode_seq | input | 1 | 1 = sequencing, 0 = tracking |
| retry_sel | input | 1 | 1 = autoretry, 0 = latch-off |
| in_good | input | NR | Per-rail input above its undervoltage level |
| in_absent | input | NR | Per-rail input not connected |
| out_good | input | NR | Per-rail output above its power-good level |
| out_low | input | NR | Per-rail output below its power-low level |
| trk_err | input | NR | Per-rail output beyond the tracking fault limit |
| gate_en | output | NR | Per-rail pass-device enable |
| dis_en | output | NR | Per-rail output discharge pulldown enable |
| soft_off | output | 1 | Controlled ramp-down in progress |
| pwr_good | output | 1 | All rails up and timeout expired |
| fault_n | output | 1 | Fault, active low |

## Verification
The hardest situation to reach from the ports is the release of a latched fault. The bench has to create a fault and then hold enable high for longer than a retry period, to show that nothing restarts. Only after that does it drop and raise enable, and it measures the full retry wait before the gates return. The stimulus gets there with a tracking-error pulse during a tracking ramp. The latch mode is selected in an idle period that is itself reached by an enable drop during a start-up delay. A second case that needs care is a select change during an autoretry wait, which must not take effect until the next pass through idle.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NR      = 3,
  parameter int DLY_CYC = 20,
  parameter int FLT_CYC = 40,
  parameter int TMO_CYC = 10
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          en,
  input  logic          mode_seq,
  input  logic          retry_sel,
  input  logic [NR-1:0] in_good,
  input  logic [NR-1:0] in_absent,
  input  logic [NR-1:0] out_good,
  input  logic [NR-1:0] out_low,
  input  logic [NR-1:0] trk_err,
  output logic [NR-1:0] gate_en,
  output logic [NR-1:0] dis_en,
  output logic          soft_off,
  output logic          pwr_good,
  output logic          fault_n
);
  localparam int RTY_CYC = 16 * FLT_CYC;
  localparam int M1      = (DLY_CYC > TMO_CYC) ? DLY_CYC : TMO_CYC;
  localparam int M2      = (M1 > RTY_CYC) ? M1 : RTY_CYC;
  localparam int CW      = $clog2(M2 + 1);
  localparam int IW      = (NR > 1) ? $clog2(NR) : 1;
  localparam logic [CW-1:0] DLY_END = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] FLT_END = CW'(FLT_CYC - 1);
  localparam logic [CW-1:0] TMO_END = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] RTY_END = CW'(RTY_CYC - 1);
  localparam logic [IW-1:0] LAST    = IW'(NR - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DLY, S_RAMP, S_SON, S_PGW, S_ON, S_RDN, S_FAST, S_LATCH, S_RWAIT
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [NR-1:0] gate_q;
  logic          fault_q, armed, mode_q, retry_q;

  logic [NR-1:0] excl;
  logic          run_ok, lo_ok, all_good, trk_hit, flt_now;

  assign excl     = in_absent & in_good;
  assign run_ok   = en & (&in_good);
  assign lo_ok    = &(out_low | excl);
  assign all_good = &(out_good | excl);
  assign trk_hit  = |(trk_err & ~excl);
  assign flt_now  = (st == S_RAMP && (trk_hit || cnt == FLT_END)) ||
                    (st == S_SON  && cnt == FLT_END) ||
                    (st == S_RDN  && trk_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      gate_q  <= '0;
      fault_q <= 1'b1;
      armed   <= 1'b0;
      mode_q  <= 1'b0;
      retry_q <= 1'b1;
    end else if (!supply_ok) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      gate_q  <= '0;
      fault_q <= 1'b1;
      armed   <= 1'b0;
    end else if (flt_now) begin
      gate_q  <= '0;
      fault_q <= 1'b0;
      cnt     <= '0;
      armed   <= 1'b0;
      st      <= retry_q ? S_RWAIT : S_LATCH;
    end else begin
      case (st)
        S_IDLE: begin
          mode_q  <= mode_seq;
          retry_q <= retry_sel;
          cnt     <= '0;
          idx     <= '0;
          if (run_ok && lo_ok) st <= S_DLY;
        end
        S_DLY: begin
          if (!run_ok) begin
            gate_q <= '0;
            st     <= S_FAST;
          end else if (mode_q && excl[idx]) begin
            cnt <= '0;
            if (idx == LAST) st <= S_PGW;
            else             idx <= idx + 1'b1;
          end else if (cnt == DLY_END) begin
            cnt <= '0;
            if (mode_q) begin
              gate_q[idx] <= 1'b1;
              st          <= S_SON;
            end else begin
              gate_q <= '1;
              st     <= S_RAMP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RAMP: begin
          if (!run_ok) begin
            gate_q <= '0;
            st     <= S_FAST;
          end else if (all_good) begin
            cnt <= '0;
            st  <= S_PGW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SON: begin
          if (!run_ok) begin
            gate_q <= '0;
            st     <= S_FAST;
          end else if (out_good[idx]) begin
            cnt <= '0;
            if (idx == LAST) st <= S_PGW;
            else begin
              idx <= idx + 1'b1;
              st  <= S_DLY;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PGW: begin
          if (!run_ok) begin
            gate_q <= '0;
            st     <= S_FAST;
          end else if (cnt == TMO_END) begin
            st <= S_ON;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ON: begin
          if (!run_ok) begin
            gate_q <= '0;
            st     <= S_RDN;
          end
        end
        S_RDN:  if (lo_ok) st <= S_IDLE;
        S_FAST: if (lo_ok) st <= S_IDLE;
        S_LATCH: begin
          if (!en) armed <= 1'b1;
          else if (armed) begin
            cnt <= '0;
            st  <= S_RWAIT;
          end
        end
        S_RWAIT: begin
          if (cnt != RTY_END) cnt <= cnt + 1'b1;
          else if (run_ok && lo_ok) begin
            cnt     <= '0;
            idx     <= '0;
            fault_q <= 1'b1;
            st      <= S_DLY;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign gate_en  = gate_q & ~excl;
  assign dis_en   = (st == S_FAST || st == S_LATCH || st == S_RWAIT) ? ~excl : '0;
  assign soft_off = (st == S_RDN);
  assign pwr_good = (st == S_ON);
  assign fault_n  = fault_q;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int NR = 3
)(
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          en,
  input logic [NR-1:0] in_good,
  input logic [NR-1:0] in_absent,
  input logic [NR-1:0] gate_en,
  input logic [NR-1:0] dis_en,
  input logic          soft_off,
  input logic          fault_n
);
  logic [NR-1:0] ex;
  assign ex = in_absent & in_good;

  p_gate_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|gate_en) |-> ($past(en) && $past(supply_ok) && (&$past(in_good))));

  p_fault_gates_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (gate_en == '0));

  p_gate_dis_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en & dis_en) == '0);

  p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> (gate_en == '0 && dis_en == '0));

  p_supply_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (gate_en == '0 && dis_en == '0 && fault_n));

  p_soft_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off |-> (gate_en == '0 && dis_en == '0));

  p_excl_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_en | dis_en) & ex) == '0);

  for (genvar i = 1; i < NR; i++) begin : g_ord
    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en[i] && !ex[i-1]) |-> gate_en[i-1]);
  end
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NR(NR)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en(en),
  .in_good(in_good), .in_absent(in_absent), .gate_en(gate_en),
  .dis_en(dis_en), .soft_off(soft_off), .fault_n(fault_n)
);

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int D = 20;
  localparam int F = 40;
  localparam int T = 10;
  localparam int R = 16 * F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1, en = 1'b0, mode_seq = 1'b0, retry_sel = 1'b1;
  logic [2:0] in_good = 3'b111, in_absent = 3'b000, out_good = 3'b000;
  logic [2:0] out_low = 3'b111, trk_err = 3'b000;
  logic [2:0] gate_en, dis_en;
  logic soft_off, pwr_good, fault_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.NR(3), .DLY_CYC(D), .FLT_CYC(F), .TMO_CYC(T)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en(en),
    .mode_seq(mode_seq), .retry_sel(retry_sel), .in_good(in_good),
    .in_absent(in_absent), .out_good(out_good), .out_low(out_low),
    .trk_err(trk_err), .gate_en(gate_en), .dis_en(dis_en),
    .soft_off(soft_off), .pwr_good(pwr_good), .fault_n(fault_n)
  );

  typedef struct {
    int         cyc;
    logic [8:0] v;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [8:0] V(input logic fn, input logic pg, input logic sf,
                                   input logic [2:0] d, input logic [2:0] g);
    return {fn, pg, sf, d, g};
  endfunction

  task automatic expA(input int c, input logic [8:0] v, input string tag);
    item_t it;
    it.cyc = c; it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops expected items as their cycle arrives
  always @(posedge clk) begin
    logic [8:0] obs;
    cyc = cyc + 1;
    #1;
    obs = {fault_n, pwr_good, soft_off, dis_en, gate_en};
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc <= cyc) begin
        checks++;
        if (q[i].cyc < cyc || obs !== q[i].v) begin
          errors++;
          $display("FAIL %s cyc=%0d actual=%b expected=%b", q[i].tag, q[i].cyc, obs, q[i].v);
        end
        q.delete(i);
      end
    end
  end

  localparam logic [8:0] IDLE = 9'b1_0_0_000_000;
  localparam logic [8:0] FLT  = 9'b0_0_0_111_000;

  initial begin
    int k, t0, t1, t2, t3, t4, t5, t6, t7, t8, f, g, f2, h, j, x, y, z, gg, s, u, e, v, w, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k = cyc; expA(k + 1, IDLE, "R1");

    // R1: missing input good, then outputs not low
    en = 1'b1; in_good = 3'b110;
    wait_to(k + 30); expA(cyc + 1, IDLE, "R1");
    in_good = 3'b111; out_low = 3'b011;
    wait_to(k + 60); expA(cyc + 1, IDLE, "R1");

    // R2/R3/R14: tracking start, mode changed mid-attempt
    out_low = 3'b111; t0 = cyc;
    expA(t0 + D, IDLE, "R2");
    expA(t0 + D + 1, V(1,0,0,3'b000,3'b111), "R2");
    wait_to(t0 + 3); mode_seq = 1'b1;
    wait_to(t0 + D + 1);
    out_good = 3'b111; out_low = 3'b000; t1 = cyc;
    expA(t1 + T, V(1,0,0,3'b000,3'b111), "R3");
    expA(t1 + T + 1, V(1,1,0,3'b000,3'b111), "R14");

    // R12: controlled ramp-down
    wait_to(t1 + T + 3); en = 1'b0; t2 = cyc;
    expA(t2 + 1, V(1,0,1,3'b000,3'b000), "R12");
    wait_to(t2 + 5); out_good = 3'b000; out_low = 3'b111; t3 = cyc;
    expA(t3 + 1, IDLE, "R12");

    // R4: sequencing order
    wait_to(t3 + 2); en = 1'b1; t4 = cyc;
    expA(t4 + D, IDLE, "R4");
    expA(t4 + D + 1, V(1,0,0,3'b000,3'b001), "R4");
    wait_to(t4 + D + 4); out_good = 3'b001; out_low = 3'b110; t5 = cyc;
    expA(t5 + D, V(1,0,0,3'b000,3'b001), "R4");
    expA(t5 + D + 1, V(1,0,0,3'b000,3'b011), "R4");
    wait_to(t5 + D + 3); out_good = 3'b011; out_low = 3'b100; t6 = cyc;
    expA(t6 + D, V(1,0,0,3'b000,3'b011), "R4");
    expA(t6 + D + 1, V(1,0,0,3'b000,3'b111), "R4");
    wait_to(t6 + D + 2); out_good = 3'b111; out_low = 3'b000; t7 = cyc;
    expA(t7 + T, V(1,0,0,3'b000,3'b111), "R3");
    expA(t7 + T + 1, V(1,1,0,3'b000,3'b111), "R4");

    // R12 in sequencing, then R6 during ramp-down
    wait_to(t7 + T + 3); en = 1'b0; t8 = cyc;
    expA(t8 + 1, V(1,0,1,3'b000,3'b000), "R12");
    wait_to(t8 + 2); trk_err = 3'b100;
    f = t8 + 3;
    expA(f, FLT, "R6");

    // R8: autoretry
    wait_to(f + 1); trk_err = 3'b000; out_low = 3'b111; out_good = 3'b000; en = 1'b1;
    expA(f + R - 1, FLT, "R8");
    expA(f + R, IDLE, "R8");
    g = f + R + D;
    expA(g - 1, IDLE, "R8");
    expA(g, V(1,0,0,3'b000,3'b001), "R8");

    // R5: timeout in sequencing; R14: retry select change ignored
    wait_to(g + 2); retry_sel = 1'b0;
    expA(g + F - 1, V(1,0,0,3'b000,3'b001), "R5");
    f2 = g + F;
    expA(f2, FLT, "R5");
    expA(f2 + R - 1, FLT, "R14");
    expA(f2 + R, IDLE, "R14");

    // R11: enable drop during start-up delay
    h = f2 + R + 2;
    wait_to(h); en = 1'b0;
    expA(h + 1, V(1,0,0,3'b111,3'b000), "R11");
    expA(h + 2, IDLE, "R11");
    wait_to(h + 3); mode_seq = 1'b0;

    // R9: latch-off
    j = h + 4; wait_to(j); en = 1'b1;
    expA(j + 1 + D, V(1,0,0,3'b000,3'b111), "R3");
    x = j + D + 3; wait_to(x); trk_err = 3'b001;
    expA(x + 1, FLT, "R6");
    wait_to(x + 2); trk_err = 3'b000;
    expA(x + 1 + R + 50, FLT, "R9");
    y = x + R + 60; wait_to(y); en = 1'b0;
    z = y + 3; wait_to(z); en = 1'b1;
    expA(z + R, FLT, "R9");
    expA(z + R + 1, IDLE, "R9");
    gg = z + 1 + R + D;
    expA(gg, V(1,0,0,3'b000,3'b111), "R9");

    // R5 in tracking, then R10 supply cycle out of the latch
    expA(gg + F - 1, V(1,0,0,3'b000,3'b111), "R5");
    expA(gg + F, FLT, "R5");
    s = gg + F + 5; wait_to(s); supply_ok = 1'b0;
    expA(s + 1, IDLE, "R10");
    u = s + 3; wait_to(u); supply_ok = 1'b1;
    expA(u + D, IDLE, "R10");
    expA(u + D + 1, V(1,0,0,3'b000,3'b111), "R10");

    // R11 during ramp, then R13 excluded rail
    e = u + D + 3; wait_to(e); en = 1'b0;
    expA(e + 1, V(1,0,0,3'b111,3'b000), "R11");
    expA(e + 2, IDLE, "R11");
    v = e + 3; wait_to(v); in_absent = 3'b010; en = 1'b1;
    expA(v + D, IDLE, "R13");
    expA(v + D + 1, V(1,0,0,3'b000,3'b101), "R13");
    w = v + D + 3; wait_to(w); out_good = 3'b101; trk_err = 3'b010; out_low = 3'b000;
    expA(w + 1, V(1,0,0,3'b000,3'b101), "R13");
    expA(w + T + 1, V(1,1,0,3'b000,3'b101), "R13");
    p = w + T + 3; wait_to(p); en = 1'b0; out_low = 3'b101; trk_err = 3'b000;
    expA(p + 1, V(1,0,1,3'b000,3'b000), "R12");
    expA(p + 2, IDLE, "R13");

    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog R1..: pending actual=%0d expected=0", q.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule